// File: doc/BRIEF.md
# Masked Vector XOR Unit

This block is the execution stage for a bitwise exclusive-OR over vectors up to 512 bits wide. A decoder upstream presents two source vectors, the current contents of the destination register, a per-element write mask and a handful of control fields. The block combines them in a single cycle and registers the result together with a valid flag. Every result bit is set where the two operand bits differ and cleared where they match. The block produces no status flags.

The work is split into 32-bit lanes. Three operating modes decide how the lanes are used:

- **Legacy mode.** Two operands are used. The old destination is the first operand, and the bits above 128 keep their previous value.
- **Three-operand mode.** No mask is applied. Everything above the vector length is cleared.
- **Masked mode.** Each element of 32 or 64 bits is XORed, kept from the old destination, or cleared, depending on its mask bit and the zeroing control. In this mode the second source may instead supply its element 0 to every element.

Internally a two-state controller, `ST_IDLE` and `ST_DONE`, tracks whether the output register holds a freshly accepted result. It has these transitions:

- `ST_IDLE` goes to `ST_DONE` on an accept, meaning `in_valid` is high.
- `ST_DONE` stays in `ST_DONE` on a further accept.
- `ST_DONE` returns to `ST_IDLE` when no input is offered.

Top module: `simd_xor_unit`

## Requirements
- R1: The cycle after a clock edge at which `in_valid` is high, `out_valid` is 1 and `out_data` holds the combined result, where each bit is the XOR of its two operand bits. After an edge at which `in_valid` is low, `out_valid` is 0.
- R2: A synchronous active-high `rst` clears `out_valid` and `out_data` to 0.
- R3: Legacy mode (`mode` = 0) computes `out_data[127:0] = old_dest[127:0] ^ src_b[127:0]`. It passes `old_dest[511:128]` through unchanged and ignores `vlen`, the mask and `src_a`.
- R4: Three-operand mode (`mode` = 1) computes `src_a ^ src_b` over 256 bits when `vlen` = 1 and over 128 bits otherwise. All higher bits are 0.
- R5: In masked mode (`mode` = 2 or 3), `vlen` selects 128, 256 or 512 bits for the codes 0, 1 and 2. Code 3 acts as 128. Every bit at or above the vector length is 0 whatever the mask. With `wide_elem` = 0 the elements are 32 bits and number 4, 8 or 16. With `wide_elem` = 1 they are 64 bits and number 2, 4 or 8.
- R6: In masked mode with `mask_en` = 0, every element inside the vector length is `src_a ^ src_b`.
- R7: In masked mode with `mask_en` = 1 and `zero_mode` = 0, element j with `mask[j]` = 0 takes the value of the same bits of `old_dest`.
- R8: In masked mode with `mask_en` = 1 and `zero_mode` = 1, element j with `mask[j]` = 0 becomes 0.
- R9: Mask bits at positions equal to or above the element count have no effect on `out_data`.
- R10: In masked mode with `bcast` = 1 and `src_mem` = 1, every element uses element 0 of `src_b`, meaning bits 31:0 for 32-bit elements or bits 63:0 for 64-bit elements.
- R11: `bcast` has no effect when `src_mem` = 0 or when the mode is not masked.
- R12: While `in_valid` is low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| mode | input | 2 | 0 legacy, 1 three-operand, 2 or 3 masked |
| vlen | input | 2 | 0 = 128, 1 = 256, 2 = 512 bits, 3 = 128 |
| wide_elem | input | 1 | 1 selects 64-bit elements, 0 selects 32-bit elements |
| bcast | input | 1 | Request element-0 broadcast of the second source |
| src_mem | input | 1 | Second source came from memory |
| mask_en | input | 1 | Apply the write mask |
| zero_mode | input | 1 | 1 clears masked-off elements, 0 merges them |
| mask | input | 16 | Per-element write mask, bit j for element j |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| old_dest | input | 512 | Current destination contents |
| out_valid | output | 1 | Result register holds a new result |
| out_data | output | 512 | Registered result |

## Verification
A wrong lane-range decode appears at once in the cycle after the accept, as a block of 32-bit words above the vector length that are nonzero or that fail to echo `old_dest`. A wrong mask-bit selection for 64-bit elements shows up as a single pair of lanes taking the merge or zero value when it should carry the XOR. A controller stuck in `ST_DONE` would leave `out_valid` high one cycle after the input strobe drops. A bad load enable would change `out_data` during an idle cycle.

// File: rtl/simd_xor_pkg.sv
package simd_xor_pkg;
    typedef enum logic [1:0] {
        MD_LEGACY = 2'd0,
        MD_THREE  = 2'd1,
        MD_MASKED = 2'd2,
        MD_MASKB  = 2'd3
    } xor_mode_e;

    typedef enum logic [1:0] {
        VL_128 = 2'd0,
        VL_256 = 2'd1,
        VL_512 = 2'd2,
        VL_RSV = 2'd3
    } xor_vlen_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } xor_state_e;
endpackage

// File: rtl/simd_xor_geom.sv
module simd_xor_geom #(
    parameter int LANE_W = 32,
    parameter int LANES  = 16,
    parameter int CW     = $clog2(LANES + 1)
) (
    input  logic [1:0]    mode,
    input  logic [1:0]    vlen,
    output logic          is_legacy,
    output logic          is_masked,
    output logic [CW-1:0] lane_limit
);
    import simd_xor_pkg::*;

    localparam int L128 = 128 / LANE_W;
    localparam int L256 = 256 / LANE_W;
    localparam int L512 = 512 / LANE_W;

    always_comb begin
        is_legacy = (xor_mode_e'(mode) == MD_LEGACY);
        is_masked = mode[1];
        lane_limit = CW'(L128);
        if (is_masked) begin
            unique case (xor_vlen_e'(vlen))
                VL_256:  lane_limit = CW'(L256);
                VL_512:  lane_limit = CW'(L512);
                default: lane_limit = CW'(L128);
            endcase
        end else if (!is_legacy && xor_vlen_e'(vlen) == VL_256) begin
            lane_limit = CW'(L256);
        end
    end
endmodule

// File: rtl/simd_xor_lane.sv
module simd_xor_lane #(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] op_a,
    input  logic [LANE_W-1:0] op_b,
    input  logic [LANE_W-1:0] prior,
    input  logic              in_range,
    input  logic              is_legacy,
    input  logic              is_masked,
    input  logic              mask_en,
    input  logic              zero_mode,
    input  logic              wide_elem,
    input  logic              mbit_narrow,
    input  logic              mbit_wide,
    output logic [LANE_W-1:0] res
);
    logic sel_bit;
    logic active;

    always_comb begin
        sel_bit = wide_elem ? mbit_wide : mbit_narrow;
        active  = !is_masked || !mask_en || sel_bit;
        if (!in_range) begin
            res = is_legacy ? prior : '0;
        end else if (is_legacy) begin
            res = prior ^ op_b;
        end else if (active) begin
            res = op_a ^ op_b;
        end else begin
            res = zero_mode ? '0 : prior;
        end
    end
endmodule

// File: rtl/simd_xor_unit.sv
module simd_xor_unit #(
    parameter int DATA_W = 512,
    parameter int LANE_W = 32,
    parameter int LANES  = DATA_W / LANE_W,
    parameter int MASK_W = LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic [1:0]        vlen,
    input  logic              wide_elem,
    input  logic              bcast,
    input  logic              src_mem,
    input  logic              mask_en,
    input  logic              zero_mode,
    input  logic [MASK_W-1:0] mask,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] old_dest,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    import simd_xor_pkg::*;

    localparam int CW = $clog2(LANES + 1);

    logic              is_legacy;
    logic              is_masked;
    logic [CW-1:0]     lane_limit;
    logic              bcast_on;
    logic [DATA_W-1:0] next_data;
    xor_state_e        st;
    xor_state_e        st_nxt;

    simd_xor_geom #(.LANE_W(LANE_W), .LANES(LANES), .CW(CW)) u_geom (
        .mode       (mode),
        .vlen       (vlen),
        .is_legacy  (is_legacy),
        .is_masked  (is_masked),
        .lane_limit (lane_limit)
    );

    assign bcast_on = is_masked && bcast && src_mem;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int PAIR = i % 2;
        logic [LANE_W-1:0] b_sel;
        logic              in_rng;

        always_comb begin
            if (bcast_on)
                b_sel = wide_elem ? src_b[PAIR*LANE_W +: LANE_W] : src_b[LANE_W-1:0];
            else
                b_sel = src_b[i*LANE_W +: LANE_W];
            in_rng = (CW'(i) < lane_limit);
        end

        simd_xor_lane #(.LANE_W(LANE_W)) u_lane (
            .op_a        (src_a[i*LANE_W +: LANE_W]),
            .op_b        (b_sel),
            .prior       (old_dest[i*LANE_W +: LANE_W]),
            .in_range    (in_rng),
            .is_legacy   (is_legacy),
            .is_masked   (is_masked),
            .mask_en     (mask_en),
            .zero_mode   (zero_mode),
            .wide_elem   (wide_elem),
            .mbit_narrow (mask[i]),
            .mbit_wide   (mask[i/2]),
            .res         (next_data[i*LANE_W +: LANE_W])
        );
    end

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (in_valid)  st_nxt = ST_DONE;
            ST_DONE: if (!in_valid) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nxt;
    end

    // result register
    always_ff @(posedge clk) begin
        if (rst)           out_data <= '0;
        else if (in_valid) out_data <= next_data;
    end

    // outputs
    always_comb begin
        out_valid = (st == ST_DONE);
    end
endmodule

// File: rtl/simd_xor_unit_chk.sv
module simd_xor_unit_chk #(
    parameter int DATA_W = 512
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        mode,
    input logic [1:0]        vlen,
    input logic [DATA_W-1:0] old_dest,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    a_r2_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_valid_drops: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    a_r3_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'd0) |=> out_data[DATA_W-1:128] == $past(old_dest[DATA_W-1:128]));

    a_r4_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'd1) |=> out_data[DATA_W-1:256] == '0);

    a_r5_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode[1] && vlen != 2'd2) |=> out_data[DATA_W-1:256] == '0);
endmodule

bind simd_xor_unit simd_xor_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mode      (mode),
    .vlen      (vlen),
    .old_dest  (old_dest),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/simd_xor_unit_bench.sv
module simd_xor_unit_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   mode;
    logic [1:0]   vlen;
    logic         wide_elem, bcast, src_mem, mask_en, zero_mode;
    logic [15:0]  mask;
    logic [511:0] src_a, src_b, old_dest;
    logic         out_valid;
    logic [511:0] out_data;

    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    simd_xor_unit u_simd_xor_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .vlen(vlen),
        .wide_elem(wide_elem), .bcast(bcast), .src_mem(src_mem),
        .mask_en(mask_en), .zero_mode(zero_mode), .mask(mask),
        .src_a(src_a), .src_b(src_b), .old_dest(old_dest),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [511:0] rnd512();
        logic [511:0] v;
        for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    // Reference built element by element from the requirements
    function automatic logic [511:0] model(
        input logic [1:0] md, input logic [1:0] vl, input logic wd,
        input logic bc, input logic mem, input logic men, input logic zm,
        input logic [15:0] mk, input logic [511:0] a, input logic [511:0] b,
        input logic [511:0] od);
        logic [511:0] r;
        int ew, vb, nel;
        logic masked, act, bb;
        r = '0;
        if (md == 2'd0) begin
            r = od;
            r[127:0] = od[127:0] ^ b[127:0];
            return r;
        end
        masked = md[1];
        ew = wd ? 64 : 32;
        if (masked) vb = (vl == 2'd1) ? 256 : (vl == 2'd2) ? 512 : 128;
        else        vb = (vl == 2'd1) ? 256 : 128;
        nel = vb / ew;
        for (int e = 0; e < nel; e++) begin
            act = !masked || !men || mk[e];
            for (int k = 0; k < ew; k++) begin
                bb = (masked && bc && mem) ? b[k] : b[e*ew + k];
                if (act)     r[e*ew + k] = a[e*ew + k] ^ bb;
                else if (zm) r[e*ew + k] = 1'b0;
                else         r[e*ew + k] = od[e*ew + k];
            end
        end
        return r;
    endfunction

    task automatic check_bit(input string tag, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic check_data(input string tag, input logic [511:0] exp);
        n_run++;
        if (out_data !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, out_data, exp);
        end
    endtask

    // drive at negedge, result sampled at the following negedge
    task automatic apply(input logic [1:0] md, input logic [1:0] vl, input logic wd,
                         input logic bc, input logic mem, input logic men,
                         input logic zm, input logic [15:0] mk,
                         input logic [511:0] a, input logic [511:0] b,
                         input logic [511:0] od);
        mode = md; vlen = vl; wide_elem = wd; bcast = bc; src_mem = mem;
        mask_en = men; zero_mode = zm; mask = mk;
        src_a = a; src_b = b; old_dest = od; in_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [511:0] a, b, od, exp, held;
        logic [15:0] mk;
        string tag;
        rst = 1'b1; in_valid = 1'b0; mode = '0; vlen = '0; wide_elem = 0;
        bcast = 0; src_mem = 0; mask_en = 0; zero_mode = 0; mask = '0;
        src_a = '0; src_b = '0; old_dest = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bit("R2 valid after reset", out_valid, 1'b0);
        check_data("R2 data after reset", '0);
        rst = 1'b0;

        // R1: truth table of XOR on constant patterns
        apply(2'd2, 2'd2, 0, 0, 0, 0, 0, '0, {512{1'b1}}, {512{1'b1}}, rnd512());
        check_bit("R1 valid", out_valid, 1'b1);
        check_data("R1 ones^ones", '0);
        apply(2'd2, 2'd2, 0, 0, 0, 0, 0, '0, {512{1'b1}}, '0, rnd512());
        check_data("R1 ones^zeros", {512{1'b1}});
        apply(2'd2, 2'd2, 1, 0, 0, 0, 0, '0, {256{2'b10}}, {128{4'b0110}}, '0);
        check_data("R1 mixed", {128{4'b1100}});

        // R12 and R1: idle cycle holds data, drops valid
        held = out_data;
        in_valid = 1'b0; src_a = rnd512(); src_b = rnd512(); old_dest = rnd512();
        @(negedge clk);
        check_bit("R1 valid drops", out_valid, 1'b0);
        check_data("R12 hold", held);

        // R5: 128-bit masked, upper cleared
        od = rnd512();
        apply(2'd2, 2'd0, 0, 0, 0, 1, 0, 16'hFFFF, {512{1'b1}}, '0, od);
        check_data("R5 vlen128 upper clear", {384'd0, {128{1'b1}}});
        apply(2'd2, 2'd1, 1, 0, 0, 0, 0, '0, {512{1'b1}}, '0, od);
        check_data("R5 vlen256 wide", {256'd0, {256{1'b1}}});

        // R9: mask bits above element count ignored
        a = rnd512(); b = rnd512(); od = rnd512();
        apply(2'd2, 2'd0, 0, 0, 0, 1, 0, 16'hFFF0, a, b, od);
        check_data("R9 high mask bits narrow", {384'd0, od[127:0]});
        apply(2'd2, 2'd1, 1, 0, 0, 1, 1, 16'hF00F, a, b, od);
        check_data("R9 high mask bits wide", {256'd0, a[255:0] ^ b[255:0]});

        // R11: broadcast ignored for register source or non-masked modes
        apply(2'd2, 2'd2, 0, 1, 0, 0, 0, '0, a, b, od);
        check_data("R11 reg source", a ^ b);
        apply(2'd1, 2'd1, 0, 1, 1, 0, 0, '0, a, b, od);
        check_data("R11 three-operand", {256'd0, a[255:0] ^ b[255:0]});
        apply(2'd0, 2'd2, 1, 1, 1, 1, 1, '0, a, b, od);
        check_data("R11 legacy", {od[511:128], od[127:0] ^ b[127:0]});

        // R10: explicit broadcast patterns
        apply(2'd2, 2'd2, 0, 1, 1, 0, 0, '0, '0, b, od);
        check_data("R10 bcast 32", {16{b[31:0]}});
        apply(2'd2, 2'd2, 1, 1, 1, 0, 0, '0, '0, b, od);
        check_data("R10 bcast 64", {8{b[63:0]}});

        // Full sweep over control space
        for (int md = 0; md < 4; md++)
        for (int vl = 0; vl < 4; vl++)
        for (int wd = 0; wd < 2; wd++)
        for (int bc = 0; bc < 2; bc++)
        for (int mem = 0; mem < 2; mem++)
        for (int men = 0; men < 2; men++)
        for (int zm = 0; zm < 2; zm++) begin
            a = rnd512(); b = rnd512(); od = rnd512(); mk = 16'($urandom);
            exp = model(2'(md), 2'(vl), 1'(wd), 1'(bc), 1'(mem), 1'(men), 1'(zm), mk, a, b, od);
            apply(2'(md), 2'(vl), 1'(wd), 1'(bc), 1'(mem), 1'(men), 1'(zm), mk, a, b, od);
            if (md == 0)                 tag = "R3 legacy sweep";
            else if (md == 1)            tag = "R4 three-operand sweep";
            else if (bc == 1 && mem == 1) tag = "R10 broadcast sweep";
            else if (men == 0)           tag = "R6 unmasked sweep";
            else if (zm == 1)            tag = "R8 zeroing sweep";
            else                         tag = "R7 merging sweep";
            check_data(tag, exp);
        end

        // R2: mid-run reset
        rst = 1'b1;
        @(negedge clk);
        check_bit("R2 valid mid-run reset", out_valid, 1'b0);
        check_data("R2 data mid-run reset", '0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule